// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit turns a 32-bit base address and a 16-bit extension word into a final 32-bit effective address for indexed addressing. The extension word picks an index register, sets the width of that index and its scale, and selects one of two forms. The short form needs a single add of base, a signed 8-bit displacement and the scaled index. The long form can suppress the base or the index. It can pull base and outer displacements of word or long size from the instruction-word stream, and it can perform one memory-indirect long read, with the index applied before or after that read.

A sequencer starts the unit with a one-cycle `start_i` pulse. The unit reads the index through a register-file read port and requests further extension words over a word-fetch handshake. It issues the indirect read over a data-read handshake that waits on a ready signal. When it finishes it pulses `done_o` for one cycle, together with the address and a step count that the sequencer can use for cycle accounting.

Top module: `ea_index_gen`

## Requirements
- R1: With extension bit 8 at 0 (short form), the result is base + sign-extended bits 7:0 + scaled index, the step count is 0, and no word fetch or data read is issued.
- R2: Extension bits 15:12 drive `idx_sel_o` to select one of 16 index registers. Bit 11 at 1 uses all 32 bits of the register. Bit 11 at 0 uses its low 16 bits, sign-extended.
- R3: The index is shifted left by the value of bits 10:9, giving a scale of 1, 2, 4 or 8.
- R4: In the long form (bit 8 at 1), bit 7 at 1 replaces the base with zero and bit 6 at 1 replaces the index with zero.
- R5: Bits 5:4 encode the base displacement size and bits 1:0 encode the outer displacement size. Value 0 or 1 means none, 2 means one word that is sign-extended, and 3 means a long taken as two words, high half first. The base displacement words are fetched before the outer ones, and exactly that number of words is consumed from the stream.
- R6: In the long form, with bits 1:0 nonzero, one long read is issued at an intermediate address. With bit 2 at 0, the intermediate address is base + base displacement + index and the result is the read data + outer displacement. With bit 2 at 1, the intermediate address is base + base displacement and the result is the read data + index + outer displacement. With bits 1:0 at zero, no read is issued and the result is base + base displacement + index.
- R7: A data-read request stays asserted, with an unchanged address, until `rd_rdy_i` is seen.
- R8: In the long form, the step count is (base displacement fetched) + (outer displacement fetched) + 1 for the index addition + (indirect read issued), so it never exceeds 4.
- R9: `done_o` is high for exactly one cycle per operation. `start_i` is ignored, and the operands given with it have no effect, while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an address computation (accepted when idle) |
| base_i | input | 32 | Base address |
| ext_i | input | 16 | Extension word |
| idx_sel_o | output | 4 | Index register select |
| idx_val_i | input | 32 | Selected index register contents |
| wf_req_o | output | 1 | Request next extension word |
| wf_ack_i | input | 1 | Extension word delivered this cycle |
| wf_data_i | input | 16 | Extension word data |
| rd_req_o | output | 1 | Indirect long read request |
| rd_addr_o | output | 32 | Indirect read address |
| rd_rdy_i | input | 1 | Read data valid this cycle |
| rd_data_i | input | 32 | Read data |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 32 | Effective address |
| steps_o | output | 3 | Step count for this computation |

## Verification
The bench uses the default widths: 32-bit addresses, 16-bit stream words and 16 index registers. With these settings the long-form control fields span only 1024 combinations of suppression, displacement sizes, indirection mode, scale and index width, so the bench sweeps all of them against an arithmetic model. Fetch and read latencies vary from run to run. The short form is swept over every index register, both index widths, every scale and signed displacements at both extremes. One run keeps start asserted with altered operands while an operation is in progress.

// File: rtl/ea_index_pkg.sv
package ea_index_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 16;
    localparam int SEL_W   = 4;
    localparam int SCALE_W = 2;
    localparam int STEP_W  = 3;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic               idx_long;
        logic [SCALE_W-1:0] scale;
        logic               full;
        logic               base_sup;
        logic               idx_sup;
        logic [1:0]         bd_size;
        logic               spare;
        logic               post;
        logic [1:0]         od_size;
    } ext_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_INDEX, ST_BDISP, ST_ODISP, ST_PRE, ST_MEM, ST_POST, ST_FIN
    } state_t;

    function automatic logic size_fetches(input logic [1:0] sz);
        return sz[1];
    endfunction

    function automatic logic size_long(input logic [1:0] sz);
        return sz == 2'b11;
    endfunction

    function automatic logic [ADDR_W-1:0] sext_byte(input logic [7:0] b);
        return {{(ADDR_W-8){b[7]}}, b};
    endfunction
endpackage

// File: rtl/ea_index_scale.sv
module ea_index_scale
    import ea_index_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W,
    parameter int SW = SCALE_W
) (
    input  logic [AW-1:0] reg_val_i,
    input  logic          use_long_i,
    input  logic [SW-1:0] scale_i,
    input  logic          suppress_i,
    output logic [AW-1:0] index_o
);
    localparam int EXT_W = AW - WW;
    logic [AW-1:0] sized;

    always_comb begin
        sized   = use_long_i ? reg_val_i : {{EXT_W{reg_val_i[WW-1]}}, reg_val_i[WW-1:0]};
        index_o = suppress_i ? '0 : (sized << scale_i);
    end
endmodule

// File: rtl/ea_disp_collect.sv
module ea_disp_collect
    import ea_index_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          word_vld_i,
    input  logic [WW-1:0] word_i,
    input  logic          long_i,
    output logic          last_o,
    output logic [AW-1:0] value_o
);
    localparam int EXT_W = AW - WW;
    logic [WW-1:0] hi_q;
    logic          second_q;

    assign last_o  = word_vld_i && (!long_i || second_q);
    assign value_o = long_i ? {hi_q, word_i} : {{EXT_W{word_i[WW-1]}}, word_i};

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            second_q <= 1'b0;
            hi_q     <= '0;
        end else if (word_vld_i) begin
            if (long_i && !second_q) begin
                hi_q     <= word_i;
                second_q <= 1'b1;
            end else begin
                second_q <= 1'b0;
            end
        end
    end

    p_long_second_r5: assert property (@(posedge clk) disable iff (rst)
        (word_vld_i && long_i && !second_q && !clear_i) |=> second_q);
endmodule

// File: rtl/ea_index_gen.sv
module ea_index_gen
    import ea_index_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [WORD_W-1:0] ext_i,
    output logic [SEL_W-1:0]  idx_sel_o,
    input  logic [ADDR_W-1:0] idx_val_i,
    output logic              wf_req_o,
    input  logic              wf_ack_i,
    input  logic [WORD_W-1:0] wf_data_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_rdy_i,
    input  logic [ADDR_W-1:0] rd_data_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [STEP_W-1:0] steps_o
);
    localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

    state_t            state_q;
    ext_t              ext_q;
    logic [ADDR_W-1:0] acc_q, idx_q, outer_q, ea_q;
    logic [STEP_W-1:0] steps_q;
    logic [ADDR_W-1:0] idx_w, disp_w;
    logic              disp_last, disp_long, fetching;

    assign fetching  = (state_q == ST_BDISP) || (state_q == ST_ODISP);
    assign disp_long = (state_q == ST_BDISP) ? size_long(ext_q.bd_size) : size_long(ext_q.od_size);

    ea_index_scale u_scale (
        .reg_val_i  (idx_val_i),
        .use_long_i (ext_q.idx_long),
        .scale_i    (ext_q.scale),
        .suppress_i (ext_q.full && ext_q.idx_sup),
        .index_o    (idx_w)
    );

    ea_disp_collect u_disp (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (state_q == ST_INDEX),
        .word_vld_i (fetching && wf_ack_i),
        .word_i     (wf_data_i),
        .long_i     (disp_long),
        .last_o     (disp_last),
        .value_o    (disp_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ext_q   <= '0;
            acc_q   <= '0;
            idx_q   <= '0;
            outer_q <= '0;
            ea_q    <= '0;
            steps_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    ext_q   <= ext_t'(ext_i);
                    acc_q   <= base_i;
                    outer_q <= '0;
                    steps_q <= '0;
                    state_q <= ST_INDEX;
                end
                ST_INDEX: begin
                    idx_q <= idx_w;
                    if (!ext_q.full) begin
                        ea_q    <= acc_q + sext_byte(ext_q[7:0]) + idx_w;
                        state_q <= ST_FIN;
                    end else begin
                        if (ext_q.base_sup) acc_q <= '0;
                        if (size_fetches(ext_q.bd_size))      state_q <= ST_BDISP;
                        else if (size_fetches(ext_q.od_size)) state_q <= ST_ODISP;
                        else                                  state_q <= ST_PRE;
                    end
                end
                ST_BDISP: if (disp_last) begin
                    acc_q   <= acc_q + disp_w;
                    steps_q <= steps_q + STEP_ONE;
                    state_q <= size_fetches(ext_q.od_size) ? ST_ODISP : ST_PRE;
                end
                ST_ODISP: if (disp_last) begin
                    outer_q <= disp_w;
                    steps_q <= steps_q + STEP_ONE;
                    state_q <= ST_PRE;
                end
                ST_PRE: begin
                    if (!ext_q.post) begin
                        acc_q   <= acc_q + idx_q;
                        steps_q <= steps_q + STEP_ONE;
                    end
                    state_q <= (ext_q.od_size != 2'b00) ? ST_MEM : ST_POST;
                end
                ST_MEM: if (rd_rdy_i) begin
                    acc_q   <= rd_data_i;
                    steps_q <= steps_q + STEP_ONE;
                    state_q <= ST_POST;
                end
                ST_POST: begin
                    ea_q <= acc_q + (ext_q.post ? idx_q : '0) + outer_q;
                    if (ext_q.post) steps_q <= steps_q + STEP_ONE;
                    state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idx_sel_o = ext_q.sel;
    assign wf_req_o  = fetching;
    assign rd_req_o  = (state_q == ST_MEM);
    assign rd_addr_o = acc_q;
    assign done_o    = (state_q == ST_FIN);
    assign ea_o      = ea_q;
    assign steps_o   = steps_q;

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_rdy_i) |=> (rd_req_o && $stable(rd_addr_o)));
    p_steps_max_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (steps_o <= STEP_W'(4)));
    p_short_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && !ext_q.full) |-> (!wf_req_o && !rd_req_o));
    p_short_steps_r1: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ext_q.full) |-> (steps_o == '0));
    p_req_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(wf_req_o && rd_req_o));
endmodule

// File: tb/ea_index_gen_bench.sv
module ea_index_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] ext_i = '0;
    logic [3:0]  idx_sel_o;
    logic [31:0] idx_val_i;
    logic        wf_req_o;
    logic        wf_ack_i = 1'b0;
    logic [15:0] wf_data_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic        rd_rdy_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic        done_o;
    logic [31:0] ea_o;
    logic [2:0]  steps_o;

    logic [31:0] rf [16];
    logic [15:0] words [4];
    int          wptr = 0, nreads = 0, rd_seen_addr = 0, hold_errs = 0, dly_sel = 0;
    int          checks = 0, failures = 0;

    assign idx_val_i = rf[idx_sel_o];
    always #(CLK_PERIOD/2) clk = ~clk;

    ea_index_gen u_ea_index_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .ext_i(ext_i),
        .idx_sel_o(idx_sel_o), .idx_val_i(idx_val_i),
        .wf_req_o(wf_req_o), .wf_ack_i(wf_ack_i), .wf_data_i(wf_data_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_rdy_i(rd_rdy_i), .rd_data_i(rd_data_i),
        .done_o(done_o), .ea_o(ea_o), .steps_o(steps_o)
    );

    function automatic logic [31:0] mem_of(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] sx16(input logic [15:0] w);
        return {{16{w[15]}}, w};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // word stream responder
    initial begin
        int d = 0;
        forever begin
            @(negedge clk);
            if (wf_ack_i) wf_ack_i = 1'b0;
            else if (wf_req_o) begin
                if (d <= 0) begin
                    wf_data_i = words[wptr % 4];
                    wptr++;
                    wf_ack_i = 1'b1;
                    d = dly_sel % 3;
                end else d--;
            end
        end
    end

    // memory responder; also tracks address stability (R7)
    initial begin
        int d = 0;
        logic tracking = 1'b0;
        logic [31:0] first_addr = '0;
        forever begin
            @(negedge clk);
            if (rd_rdy_i) rd_rdy_i = 1'b0;
            else if (rd_req_o) begin
                if (!tracking) begin
                    tracking = 1'b1;
                    first_addr = rd_addr_o;
                    d = dly_sel % 4;
                end
                if (rd_addr_o !== first_addr) hold_errs++;
                if (d <= 0) begin
                    rd_data_i = mem_of(rd_addr_o);
                    rd_seen_addr = rd_addr_o;
                    nreads++;
                    rd_rdy_i = 1'b1;
                    tracking = 1'b0;
                end else d--;
            end
        end
    end

    task automatic run(input logic [31:0] base, input logic [15:0] ext, input logic hold, input string tag);
        logic [31:0] x, b, od, raddr, ea_e;
        int wp, st, nrd;
        int to;
        x = ext[11] ? rf[ext[15:12]] : sx16(rf[ext[15:12]][15:0]);
        x = x << ext[10:9];
        wp = 0; st = 0; nrd = 0; od = '0; raddr = '0;
        if (!ext[8]) begin
            ea_e = base + {{24{ext[7]}}, ext[7:0]} + x;
        end else begin
            b = ext[7] ? 32'h0 : base;
            if (ext[6]) x = '0;
            if (ext[5:4] == 2'd2) begin b = b + sx16(words[0]); wp = 1; st++; end
            if (ext[5:4] == 2'd3) begin b = b + {words[0], words[1]}; wp = 2; st++; end
            if (ext[1:0] == 2'd2) begin od = sx16(words[wp]); wp = wp + 1; st++; end
            if (ext[1:0] == 2'd3) begin od = {words[wp], words[wp+1]}; wp = wp + 2; st++; end
            st++;
            if (!ext[2]) b = b + x;
            if (ext[1:0] != 2'd0) begin raddr = b; b = mem_of(b); nrd = 1; st++; end
            if (ext[2]) b = b + x;
            ea_e = b + od;
        end
        wptr = 0; nreads = 0; hold_errs = 0;
        @(negedge clk);
        start_i = 1'b1; base_i = base; ext_i = ext;
        @(negedge clk);
        if (hold) begin base_i = ~base; ext_i = ~ext; end
        else start_i = 1'b0;
        to = 0;
        while (!done_o && to < 200) begin @(negedge clk); to++; end
        start_i = 1'b0;
        if (!done_o) begin
            failures++;
            $display("FAIL R9 %s no done actual=0 expected=1", tag);
            return;
        end
        check({tag, " ea"}, ea_o, ea_e);
        check("R8 steps", 32'(steps_o), 32'(st));
        check("R5 words consumed", 32'(wptr), 32'(wp));
        check("R6 read count", 32'(nreads), 32'(nrd));
        if (nrd != 0) check("R6 read address", 32'(rd_seen_addr), raddr);
        check("R7 read address held", 32'(hold_errs), 32'd0);
        @(negedge clk);
        check("R9 done one cycle", 32'(done_o), 32'd0);
        dly_sel++;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < 16; i++)
            rf[i] = 32'h0123_0000 * i + ((i % 2 == 1) ? 32'h0000_FF80 : 32'h0000_0044) + i;
        for (int i = 0; i < 4; i++) words[i] = 16'h8001 + 16'h3C35 * i[15:0];
        repeat (3) @(negedge clk);
        // reset state
        check("R9 reset done", 32'(done_o), 32'd0);
        check("R5 reset fetch req", 32'(wf_req_o), 32'd0);
        check("R7 reset read req", 32'(rd_req_o), 32'd0);
        rst = 1'b0;
        // R1 R2 R3 short form sweep
        n = 0;
        for (int r = 0; r < 16; r++)
            for (int wl = 0; wl < 2; wl++)
                for (int sc = 0; sc < 4; sc++)
                    for (int dsel = 0; dsel < 4; dsel++) begin
                        logic [7:0] dd;
                        dd = (dsel == 0) ? 8'h7F : (dsel == 1) ? 8'h80 : (dsel == 2) ? 8'h00 : 8'hFF;
                        run(32'h0004_0000 + 32'(n * 4099), {r[3:0], wl[0], sc[1:0], 1'b0, dd}, 1'b0, "R1 R2 R3 short");
                        n++;
                    end
        // R4 R5 R6 long form sweep over all control combinations
        for (int ctl = 0; ctl < 1024; ctl++) begin
            logic [15:0] e;
            logic [9:0] c;
            c = ctl[9:0];
            e = {4'(ctl % 16), c[9], c[8:7], 1'b1, c[6], c[5], c[4:3], 1'b0, c[2], c[1:0]};
            for (int i = 0; i < 4; i++) words[i] = 16'h8001 + 16'h3C35 * i[15:0] + 16'(ctl * 7);
            run(32'h1000_0000 + 32'(ctl * 65537), e, 1'b0, "R4 R5 R6 long");
        end
        // R9 start held with altered operands during an operation
        run(32'h2468_ACE0, 16'b0101_1_01_1_0_0_11_0_1_11, 1'b1, "R9 start ignored busy");
        run(32'h0000_1000, 16'h3A85, 1'b1, "R9 start ignored short");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule